// File: doc/BRIEF.md
# Shared Ready/Data Pin Framer

This block serializes a converter result onto one output pin that also carries the announcement that a new result exists. Time is divided into repeating frames of 384 master clocks. Each frame opens with a 36-clock ready window. In that window the pin rests high, then drops low for a short strobe, then returns high. The frame closes with a 348-clock data window, in which the host reads the result one bit at a time by pulsing its serial clock.

The result producer presents a 24-bit two's-complement word with a one-clock load strobe. The strobe is accepted only in the first six clocks of a frame. At the boundary into the data window the accepted word is copied into a shift register. The pin then shows its most significant bit, and each host falling edge moves the pin to the next lower bit. Any bits still unread when the next frame starts are dropped, because the shift register is refilled at the next data window.

Top module: `rdpin_framer`

## Requirements
- R1: Frames repeat every 384 master clocks. Frame position 0 is the first clock after reset is released. Positions 0 to 35 form the ready window and positions 36 to 383 form the data window.
- R2: At frame positions 0 to 23 the pin is high.
- R3: At frame positions 24 to 29 the pin is low. This is a strobe exactly 6 clocks wide.
- R4: At frame positions 30 to 35 the pin is high.
- R5: A load strobe sampled at frame positions 0 to 5 stores the presented word. A strobe at any other position leaves the stored word unchanged, and the word shown in the next data window is the earlier one.
- R6: At frame position 36 the pin shows bit 23 of the most recently stored word. Bits left unread from the previous data window are discarded.
- R7: In the data window, each host SCLK falling edge moves the pin to the next lower bit. Bit 23 goes first and bit 0 goes last. After 24 advances the pin shows 0, because zeros are shifted in.
- R8: An SCLK falling edge whose synchronized detection lands inside the ready window does not advance the data. This includes a fall at position 33, which is detected at position 35.
- R9: Reset is synchronous and active low. It clears the stored word to zero and restarts the frame at position 0, with the pin high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| result_i | input | 24 | Result word, two's complement |
| result_load_i | input | 1 | One-clock strobe that stores result_i |
| sclk_i | input | 1 | Host serial clock, idle low, asynchronous to clk |
| pin_o | output | 1 | Shared ready-strobe and data pin |

## Verification
The pin is decoded combinationally from the frame position and the head of the shift register. A ready-window level therefore appears in the same clock as its frame position, and the bench samples it on the falling clk edge of that position. A load strobe takes effect on the next rising edge. An SCLK fall reaches the pin after three rising edges: two synchronizer stages and then the shift. The bench waits four falling clk edges after each SCLK fall before it compares, so it never samples inside that settling interval. Frame positions are tracked by a bench counter that restarts at reset. Stimulus aimed at a window boundary, such as a load at position 5 or 6, or an SCLK fall at position 33, is placed exactly on those positions.

// File: rtl/rdpin_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the shared ready/data pin framer.
// Assumes: the phase order of a frame is QUIET, LOW, GAP, DATA.
package rdpin_pkg;

    typedef enum logic [1:0] {
        PH_QUIET = 2'd0,
        PH_LOW   = 2'd1,
        PH_GAP   = 2'd2,
        PH_DATA  = 2'd3
    } rdpin_phase_e;

    // Phase that must follow the given one within a frame.
    function automatic rdpin_phase_e rdpin_next_phase(input rdpin_phase_e ph);
        case (ph)
            PH_QUIET: return PH_LOW;
            PH_LOW:   return PH_GAP;
            PH_GAP:   return PH_DATA;
            default:  return PH_QUIET;
        endcase
    endfunction

endpackage

// File: rtl/rdpin_timer.sv
`timescale 1ns/1ps
// Module: rdpin_timer
// Counts master clocks within a frame and decodes the frame phase.
// It also decodes the load window and the clock that enters the data window.
// Assumes: QUIET+LOW+GAP < CYCLE_CLKS and LOAD_CLKS < QUIET+LOW+GAP.
module rdpin_timer
    import rdpin_pkg::*;
#(
    parameter int CYCLE_CLKS = 384,
    parameter int QUIET_CLKS = 24,
    parameter int LOW_CLKS   = 6,
    parameter int GAP_CLKS   = 6,
    parameter int LOAD_CLKS  = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    output rdpin_phase_e phase_o,
    output logic         load_win_o,
    output logic         data_start_o,
    output logic         data_win_o
);
    localparam int POS_W      = $clog2(CYCLE_CLKS);
    localparam int READY_CLKS = QUIET_CLKS + LOW_CLKS + GAP_CLKS;
    localparam logic [POS_W-1:0] POS_LAST  = POS_W'(CYCLE_CLKS - 1);
    localparam logic [POS_W-1:0] LOW_BEG   = POS_W'(QUIET_CLKS);
    localparam logic [POS_W-1:0] GAP_BEG   = POS_W'(QUIET_CLKS + LOW_CLKS);
    localparam logic [POS_W-1:0] DATA_BEG  = POS_W'(READY_CLKS);
    localparam logic [POS_W-1:0] LOAD_END  = POS_W'(LOAD_CLKS);
    localparam logic [POS_W-1:0] START_POS = POS_W'(READY_CLKS - 1);

    logic [POS_W-1:0] pos_q;

    // Frame position counter, wrapping at the frame length.
    always_ff @(posedge clk) begin
        if (!rst_n)                pos_q <= '0;
        else if (pos_q == POS_LAST) pos_q <= '0;
        else                       pos_q <= pos_q + 1'b1;
    end

    // Phase decode from the frame position.
    always_comb begin
        if (pos_q < LOW_BEG)       phase_o = PH_QUIET;
        else if (pos_q < GAP_BEG)  phase_o = PH_LOW;
        else if (pos_q < DATA_BEG) phase_o = PH_GAP;
        else                       phase_o = PH_DATA;
    end

    // Window strobes for the load and shift logic.
    assign load_win_o   = (pos_q < LOAD_END);
    assign data_start_o = (pos_q == START_POS);
    assign data_win_o   = (phase_o == PH_DATA);

    AST_POS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_q == POS_LAST) |=> (pos_q == '0)); // R1
    AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o != $past(phase_o)) |-> (phase_o == rdpin_next_phase($past(phase_o)))); // R1
endmodule

// File: rtl/rdpin_sclk_edge.sv
`timescale 1ns/1ps
// Module: rdpin_sclk_edge
// Brings the host serial clock into the master clock domain.
// It flags each falling edge for exactly one master clock.
// Assumes: SCLK idles low and each level lasts longer than two master clocks.
module rdpin_sclk_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    output logic fall_o
);
    logic [STAGES:0] chain_q;

    // Synchronizer chain plus one extra stage used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-1:0], sclk_i};
    end

    // Falling edge: the older sample is high and the newer sample is low.
    assign fall_o = chain_q[STAGES] & ~chain_q[STAGES-1];

    AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |=> !fall_o); // R7
endmodule

// File: rtl/rdpin_shifter.sv
`timescale 1ns/1ps
// Module: rdpin_shifter
// Holds the stored result and a shift register that serializes it MSB first.
// Assumes: data_start_i precedes data_win_i by one clock, and a reload takes priority over a shift.
module rdpin_shifter #(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] result_i,
    input  logic              load_i,
    input  logic              load_win_i,
    input  logic              data_start_i,
    input  logic              data_win_i,
    input  logic              fall_i,
    output logic              msb_o
);
    logic [DATA_W-1:0] result_q;
    logic [DATA_W-1:0] shreg_q;

    // Store the result only when the strobe falls in the load window.
    always_ff @(posedge clk) begin
        if (!rst_n)                       result_q <= '0;
        else if (load_i && load_win_i)    result_q <= result_i;
    end

    // Refill at data-window entry, then shift left on each qualified fall.
    always_ff @(posedge clk) begin
        if (!rst_n)                       shreg_q <= '0;
        else if (data_start_i)            shreg_q <= result_q;
        else if (data_win_i && fall_i)    shreg_q <= {shreg_q[DATA_W-2:0], 1'b0};
    end

    assign msb_o = shreg_q[DATA_W-1];

    AST_LOAD_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_i && load_win_i) |=> $stable(result_q)); // R5
    AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        data_start_i |=> (shreg_q == $past(result_q))); // R6
    AST_HOLD_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (!data_win_i && !data_start_i) |=> $stable(shreg_q)); // R8
endmodule

// File: rtl/rdpin_framer.sv
`timescale 1ns/1ps
// Module: rdpin_framer (top)
// Drives one pin with a timed ready strobe followed by serial result data.
// Assumes: the host drives SCLK low when idle and reads only in the data window.
module rdpin_framer
    import rdpin_pkg::*;
#(
    parameter int DATA_W      = 24,
    parameter int CYCLE_CLKS  = 384,
    parameter int QUIET_CLKS  = 24,
    parameter int LOW_CLKS    = 6,
    parameter int GAP_CLKS    = 6,
    parameter int LOAD_CLKS   = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] result_i,
    input  logic              result_load_i,
    input  logic              sclk_i,
    output logic              pin_o
);
    rdpin_phase_e phase;
    logic load_win, data_start, data_win, sclk_fall, data_bit;

    rdpin_timer #(
        .CYCLE_CLKS(CYCLE_CLKS), .QUIET_CLKS(QUIET_CLKS), .LOW_CLKS(LOW_CLKS),
        .GAP_CLKS(GAP_CLKS), .LOAD_CLKS(LOAD_CLKS)
    ) timer_i (
        .clk(clk), .rst_n(rst_n), .phase_o(phase), .load_win_o(load_win),
        .data_start_o(data_start), .data_win_o(data_win)
    );

    rdpin_sclk_edge #(.STAGES(SYNC_STAGES)) edge_i (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .fall_o(sclk_fall)
    );

    rdpin_shifter #(.DATA_W(DATA_W)) shifter_i (
        .clk(clk), .rst_n(rst_n), .result_i(result_i), .load_i(result_load_i),
        .load_win_i(load_win), .data_start_i(data_start), .data_win_i(data_win),
        .fall_i(sclk_fall), .msb_o(data_bit)
    );

    // Pin multiplexer: ready-window levels, then the data bit.
    always_comb begin
        case (phase)
            PH_LOW:  pin_o = 1'b0;
            PH_DATA: pin_o = data_bit;
            default: pin_o = 1'b1;
        endcase
    end

    AST_STROBE_AFTER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pin_o) && phase == PH_LOW) |-> ($past(phase) == PH_QUIET)); // R3
    AST_GAP_HIGH_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(phase) == PH_LOW && phase == PH_GAP) |-> $rose(pin_o)); // R4
endmodule

// File: tb/rdpin_framer_tb_top.sv
`timescale 1ns/1ps
module rdpin_framer_tb_top;
    localparam int CYC = 384;
    localparam int NVEC = 6;
    localparam logic [23:0] VEC [NVEC] = '{24'h7FFFFF, 24'h800000, 24'h000000,
                                           24'hA5C3F1, 24'hFFFFFF, 24'h123456};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [23:0] result_i = '0;
    logic result_load_i = 1'b0;
    logic sclk_i = 1'b0;
    logic pin_o;

    int checks = 0;
    int errors = 0;
    int bpos = 0;
    int clk_count = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rdpin_framer dut_i (
        .clk(clk), .rst_n(rst_n), .result_i(result_i),
        .result_load_i(result_load_i), .sclk_i(sclk_i), .pin_o(pin_o)
    );

    // Frame position expected from R1: restarts at reset, wraps at 384.
    always @(posedge clk) begin
        clk_count <= clk_count + 1;
        if (!rst_n)            bpos <= 0;
        else if (bpos == CYC-1) bpos <= 0;
        else                   bpos <= bpos + 1;
    end

    task automatic check(input logic got, input logic exp, input string tag);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: pin=%0b expected %0b (pos %0d)", tag, got, exp, bpos);
        end
    endtask

    task automatic check_int(input int got, input int exp, input string tag);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic wait_pos(input int p);
        @(negedge clk);
        while (bpos != p) @(negedge clk);
    endtask

    task automatic load_at(input int p, input logic [23:0] v);
        wait_pos(p);
        result_i = v;
        result_load_i = 1'b1;
        @(negedge clk);
        result_load_i = 1'b0;
    endtask

    task automatic sclk_pulse();
        sclk_i = 1'b1;
        repeat (2) @(negedge clk);
        sclk_i = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // Read n bits starting at position 37; compare each against v.
    task automatic read_word(input logic [23:0] v, input int n, input string tag);
        wait_pos(37);
        check(pin_o, v[23], tag);
        for (int i = 1; i < n; i++) begin
            sclk_pulse();
            check(pin_o, v[23-i], tag);
        end
    endtask

    task automatic do_reset(input int cycles);
        rst_n = 1'b0;
        repeat (cycles) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete, got timeout expected completion");
        finish_run();
    end

    initial begin
        int t0, t1, tlow;
        do_reset(4);
        // R9: reset state: pin high and stored word zero.
        check(pin_o, 1'b1, "R9 pin after reset");
        read_word(24'h000000, 3, "R9 cleared word");

        // R2 R3 R4: ready-window levels at every position.
        wait_pos(0);
        for (int p = 0; p < 36; p++) begin
            if (p < 24)      check(pin_o, 1'b1, "R2 quiet high");
            else if (p < 30) check(pin_o, 1'b0, "R3 strobe low");
            else             check(pin_o, 1'b1, "R4 gap high");
            @(negedge clk);
        end

        // Vector table: load, read all 24 bits, then one extra advance reads 0.
        for (int k = 0; k < NVEC; k++) begin
            load_at(2, VEC[k]);
            read_word(VEC[k], 24, "R6 R7 vector bit");
            sclk_pulse();
            check(pin_o, 1'b0, "R7 zero fill");
        end

        // R1 and R3: frame period and strobe width measured on the pin (all-ones data).
        load_at(1, 24'hFFFFFF);
        wait_pos(100);
        while (pin_o !== 1'b0) @(negedge clk);
        t0 = clk_count;
        while (pin_o !== 1'b1) @(negedge clk);
        tlow = clk_count - t0;
        check_int(tlow, 6, "R3 strobe width");
        while (pin_o !== 1'b0) @(negedge clk);
        t1 = clk_count;
        check_int(t1 - t0, CYC, "R1 frame period");

        // R6: partial read, then the next frame shows the new word from bit 23.
        load_at(1, 24'h5A0F0F);
        read_word(24'h5A0F0F, 3, "R6 partial read");
        load_at(0, 24'h3C3C3C);
        read_word(24'h3C3C3C, 2, "R6 discard unread");

        // R5: a load at position 5 is stored; a load at position 6 is ignored.
        load_at(5, 24'hC00001);
        read_word(24'hC00001, 2, "R5 load at last window clock");
        load_at(6, 24'h7FFFFF);
        read_word(24'hC00001, 2, "R5 load after window ignored");
        load_at(200, 24'h7FFFFF);
        read_word(24'hC00001, 2, "R5 load in data window ignored");

        // R8: SCLK falls in the ready window, including one detected at position 35.
        load_at(2, 24'hB00000);
        wait_pos(10);
        sclk_i = 1'b1;
        wait_pos(14);
        sclk_i = 1'b0;
        wait_pos(30);
        sclk_i = 1'b1;
        wait_pos(33);
        sclk_i = 1'b0;
        read_word(24'hB00000, 4, "R8 ready-window SCLK ignored");

        // R9: reset during the data window clears the word and restarts the frame.
        load_at(2, 24'hFFFFFF);
        wait_pos(50);
        do_reset(3);
        check(pin_o, 1'b1, "R9 pin after mid-frame reset");
        wait_pos(24);
        check(pin_o, 1'b0, "R9 R1 frame restarted");
        read_word(24'h000000, 2, "R9 word cleared");

        finish_run();
    end
endmodule